// File: doc/BRIEF.md
# Quadrant Array Readout Sequencer

This block generates the addressing and control strobes that scan a photodiode array built as four equal square quadrants behind a row and column multiplexer. The four quadrants are addressed together. One row/column address drives all of them, and each quadrant has its own serial output and its own converter lane. For every pixel the block presents the address and lets the multiplexer settle for a programmable number of clocks. It then issues one single-cycle strobe. In read mode this strobe is a non-destructive sample: a start-conversion pulse on every lane plus a pixel-valid flag. In reset mode it is a pixel reset.

A scan covers either the whole quadrant or a small square sub-window. The sub-window is meant for fast repeated guiding reads. Its origin comes from the start command and is clamped so that the window stays inside the quadrant. A start request is only taken while the block is idle. A one-cycle frame-done pulse follows the last strobe.

Top module: `quad_readout_seq`

## Requirements
- R1: While reset is low, and afterwards until a start is accepted, `busy_o`, `sel_o`, `conv_o`, `pix_rst_o`, `pix_valid_o` and `frame_done_o` are all 0, and `row_o`/`col_o` read 0 after reset.
- R2: A start taken in idle with `win_en_i`=0 scans rows 0 to QUAD_DIM-1. Within each row it scans columns 0 to QUAD_DIM-1, column fastest. The first address appears in the cycle after the accepting edge.
- R3: With `win_en_i`=1 the scan covers a WIN_DIM x WIN_DIM square whose top-left corner is the (clamped) origin, in the same row-major, column-fastest order.
- R4: In window mode, an origin coordinate larger than QUAD_DIM-WIN_DIM is replaced by QUAD_DIM-WIN_DIM. The row and column are clamped independently. Smaller values are used unchanged.
- R5: For each pixel, the address is held with `sel_o`=1 and no strobe for S+1 cycles, where S is `settle_i` sampled at start. It is then held for exactly one strobe cycle.
- R6: With `mode_reset_i`=0 at start, every strobe cycle drives all NQUAD bits of `conv_o` and `pix_valid_o` high, and `pix_rst_o` low.
- R7: With `mode_reset_i`=1 at start, every strobe cycle drives `pix_rst_o` high, while `conv_o` and `pix_valid_o` stay low.
- R8: `frame_done_o` is high for exactly the one cycle after the last strobe, with `sel_o` low. `busy_o` is high from the first address cycle through that cycle and then drops. The address holds the last pixel.
- R9: A start request while `busy_o` is high is ignored. Mode, window, origin and settle count of the running scan stay unchanged, and no new scan follows the frame-done cycle unless start is asserted in idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Scan request, taken only when idle |
| mode_reset_i | input | 1 | 0 = non-destructive read, 1 = pixel reset |
| win_en_i | input | 1 | 0 = full quadrant, 1 = sub-window |
| win_row_i | input | AW | Requested window origin row |
| win_col_i | input | AW | Requested window origin column |
| settle_i | input | SW | Extra settle clocks S per pixel |
| row_o | output | AW | Row address shared by all quadrants |
| col_o | output | AW | Column address shared by all quadrants |
| sel_o | output | 1 | Pixel selected (settle and strobe cycles) |
| conv_o | output | NQUAD | Start-conversion pulse per quadrant lane |
| pix_rst_o | output | 1 | Pixel reset strobe |
| pix_valid_o | output | 1 | Sample valid, aligned with conversion |
| frame_done_o | output | 1 | One-cycle end-of-scan pulse |
| busy_o | output | 1 | Scan in progress |

## Verification
Two events can arrive in the same cycle: a new start request and the final part of the running scan, meaning the last strobe or the frame-done cycle. Both also overlap with ordinary settle and strobe cycles. The bench drives random start pulses with random mode, window, origin and settle values on every cycle of chosen scans, including the frame-done cycle itself. It then checks that every output keeps following the model built from the original parameters. It also checks that the block is idle and stays idle once start is withdrawn.

// File: rtl/qrs_pkg.sv
// Package: shared types of the quadrant readout sequencer.
// Assumes: nothing beyond IEEE 1800-2017.
package qrs_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SETTLE = 2'd1,
        ST_STROBE = 2'd2,
        ST_FINISH = 2'd3
    } seq_state_t;
endpackage

// File: rtl/qrs_origin_clamp.sv
// Module: clamps one window origin coordinate so a window fits the quadrant.
// Assumes: LIMIT = quadrant size minus window size, non-negative.
module qrs_origin_clamp #(
    parameter int AW    = 9,
    parameter int LIMIT = 496
) (
    input  logic [AW-1:0] org_i,
    output logic [AW-1:0] org_o
);
    localparam logic [AW-1:0] LIM = AW'(LIMIT);

    // Replace an out-of-range coordinate by the largest legal one.
    always_comb begin
        org_o = (org_i > LIM) ? LIM : org_i;
        // R4: clamped value never exceeds the limit
        p_clamp_limit_r4: assert (org_o <= LIM);
    end
endmodule

// File: rtl/qrs_addr_scan.sv
// Module: row-major pixel address walker over a latched rectangle.
// Assumes: base <= end per axis at load; step is only issued when not last.
module qrs_addr_scan #(
    parameter int AW = 9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic          step_i,
    input  logic [AW-1:0] row_base_i,
    input  logic [AW-1:0] col_base_i,
    input  logic [AW-1:0] row_end_i,
    input  logic [AW-1:0] col_end_i,
    output logic [AW-1:0] row_o,
    output logic [AW-1:0] col_o,
    output logic          last_o
);
    logic [AW-1:0] row_q, col_q, col_base_q, row_end_q, col_end_q;

    // Latch the rectangle on load, then advance column first, row second.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            row_q      <= '0;
            col_q      <= '0;
            col_base_q <= '0;
            row_end_q  <= '0;
            col_end_q  <= '0;
        end else if (load_i) begin
            row_q      <= row_base_i;
            col_q      <= col_base_i;
            col_base_q <= col_base_i;
            row_end_q  <= row_end_i;
            col_end_q  <= col_end_i;
        end else if (step_i) begin
            if (col_q == col_end_q) begin
                col_q <= col_base_q;
                row_q <= row_q + 1'b1;
            end else begin
                col_q <= col_q + 1'b1;
            end
        end
    end

    assign row_o  = row_q;
    assign col_o  = col_q;
    assign last_o = (row_q == row_end_q) && (col_q == col_end_q);

    // R3: column stays inside the latched span
    p_col_in_span_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (col_q >= col_base_q) && (col_q <= col_end_q));
    // R8: the controller never steps past the last pixel
    p_no_step_past_last_r8: assert property (@(posedge clk) disable iff (!rst_n)
        step_i |-> !last_o);
endmodule

// File: rtl/qrs_settle_timer.sv
// Module: down-counter that times the multiplexer settle interval.
// Assumes: load has priority; count rests at zero when not loaded.
module qrs_settle_timer #(
    parameter int SW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic [SW-1:0] val_i,
    output logic          done_o
);
    logic [SW-1:0] cnt_q;

    // Load the settle count, then count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)            cnt_q <= '0;
        else if (load_i)       cnt_q <= val_i;
        else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
    end

    assign done_o = (cnt_q == '0);
endmodule

// File: rtl/quad_readout_seq.sv
// Module: four-quadrant readout sequencer. Drives a shared row/column
// address, waits a settle interval, then issues one conversion or reset
// strobe per pixel; full-quadrant or clamped sub-window scans.
// Assumes: all quadrants share one address; one converter lane per quadrant.
module quad_readout_seq
    import qrs_pkg::*;
#(
    parameter int NQUAD    = 4,
    parameter int QUAD_DIM = 512,
    parameter int WIN_DIM  = 16,
    parameter int SW       = 8,
    localparam int AW      = $clog2(QUAD_DIM)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             mode_reset_i,
    input  logic             win_en_i,
    input  logic [AW-1:0]    win_row_i,
    input  logic [AW-1:0]    win_col_i,
    input  logic [SW-1:0]    settle_i,
    output logic [AW-1:0]    row_o,
    output logic [AW-1:0]    col_o,
    output logic             sel_o,
    output logic [NQUAD-1:0] conv_o,
    output logic             pix_rst_o,
    output logic             pix_valid_o,
    output logic             frame_done_o,
    output logic             busy_o
);
    localparam int            WMAX     = QUAD_DIM - WIN_DIM;
    localparam logic [AW-1:0] WIN_SPAN = AW'(WIN_DIM - 1);
    localparam logic [AW-1:0] FULL_END = AW'(QUAD_DIM - 1);

    seq_state_t    state_q;
    logic          mode_q;
    logic [SW-1:0] settle_q;
    logic [AW-1:0] org_in [2];
    logic [AW-1:0] org_cl [2];
    logic [AW-1:0] row_base, col_base, row_end, col_end;
    logic          accept, step, timer_load, timer_done, scan_last, strobe;
    logic [SW-1:0] timer_val;

    assign org_in[0] = win_row_i;
    assign org_in[1] = win_col_i;

    // One clamp per axis.
    for (genvar ax = 0; ax < 2; ax++) begin : g_clamp
        qrs_origin_clamp #(.AW(AW), .LIMIT(WMAX)) u_clamp (
            .org_i (org_in[ax]),
            .org_o (org_cl[ax])
        );
    end

    // Pick the scan rectangle from the window select.
    always_comb begin
        if (win_en_i) begin
            row_base = org_cl[0];
            col_base = org_cl[1];
            row_end  = org_cl[0] + WIN_SPAN;
            col_end  = org_cl[1] + WIN_SPAN;
        end else begin
            row_base = '0;
            col_base = '0;
            row_end  = FULL_END;
            col_end  = FULL_END;
        end
    end

    assign accept     = (state_q == ST_IDLE) && start_i;
    assign strobe     = (state_q == ST_STROBE);
    assign step       = strobe && !scan_last;
    assign timer_load = accept || step;
    assign timer_val  = accept ? settle_i : settle_q;

    qrs_addr_scan #(.AW(AW)) u_scan (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (accept),
        .step_i     (step),
        .row_base_i (row_base),
        .col_base_i (col_base),
        .row_end_i  (row_end),
        .col_end_i  (col_end),
        .row_o      (row_o),
        .col_o      (col_o),
        .last_o     (scan_last)
    );

    qrs_settle_timer #(.SW(SW)) u_settle (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (timer_load),
        .val_i  (timer_val),
        .done_o (timer_done)
    );

    // Sequence idle -> settle -> strobe per pixel -> finish; latch scan setup.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            mode_q   <= 1'b0;
            settle_q <= '0;
        end else begin
            case (state_q)
                ST_IDLE: if (start_i) begin
                    mode_q   <= mode_reset_i;
                    settle_q <= settle_i;
                    state_q  <= ST_SETTLE;
                end
                ST_SETTLE: if (timer_done) state_q <= ST_STROBE;
                ST_STROBE: state_q <= scan_last ? ST_FINISH : ST_SETTLE;
                default:   state_q <= ST_IDLE;
            endcase
        end
    end

    // Per-lane conversion strobes, one per quadrant output.
    for (genvar q = 0; q < NQUAD; q++) begin : g_lane
        assign conv_o[q] = strobe && !mode_q;
    end

    assign sel_o        = (state_q == ST_SETTLE) || strobe;
    assign pix_rst_o    = strobe && mode_q;
    assign pix_valid_o  = strobe && !mode_q;
    assign frame_done_o = (state_q == ST_FINISH);
    assign busy_o       = (state_q != ST_IDLE);

    // R5: address holds from a settle cycle into the following cycle
    p_addr_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_o && !(|conv_o) && !pix_rst_o) |=> ($stable(row_o) && $stable(col_o)));
    // R5: a strobe lasts exactly one cycle
    p_strobe_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ((|conv_o) || pix_rst_o) |=> !((|conv_o) || pix_rst_o));
    // R8: frame-done directly follows a strobe
    p_done_after_strobe_r8: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done_o |-> $past((|conv_o) || pix_rst_o));
    // R9: setup of a running scan cannot change
    p_setup_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |=> ($stable(mode_q) && $stable(settle_q)));
endmodule

// File: tb/quad_readout_seq_test.sv
module quad_readout_seq_test;
    localparam int NQ = 4;
    localparam int Q  = 32;
    localparam int W  = 16;
    localparam int SB = 4;
    localparam int AW = $clog2(Q);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0, mode_reset_i = 1'b0, win_en_i = 1'b0;
    logic [AW-1:0] win_row_i = '0, win_col_i = '0;
    logic [SB-1:0] settle_i = '0;
    logic [AW-1:0] row_o, col_o;
    logic          sel_o, pix_rst_o, pix_valid_o, frame_done_o, busy_o;
    logic [NQ-1:0] conv_o;

    int n_checks = 0;
    int n_fail   = 0;

    always #10 clk = ~clk;

    quad_readout_seq #(.NQUAD(NQ), .QUAD_DIM(Q), .WIN_DIM(W), .SW(SB)) uut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .mode_reset_i(mode_reset_i),
        .win_en_i(win_en_i), .win_row_i(win_row_i), .win_col_i(win_col_i),
        .settle_i(settle_i), .row_o(row_o), .col_o(col_o), .sel_o(sel_o),
        .conv_o(conv_o), .pix_rst_o(pix_rst_o), .pix_valid_o(pix_valid_o),
        .frame_done_o(frame_done_o), .busy_o(busy_o)
    );

    function automatic logic [31:0] pk(logic b, logic s, logic [NQ-1:0] cv, logic rs,
                                       logic vl, logic dn, logic [AW-1:0] r, logic [AW-1:0] c);
        return {13'd0, b, s, cv, rs, vl, dn, r, c};
    endfunction

    function automatic int clampf(int o);
        return (o > Q - W) ? Q - W : o;
    endfunction

    task automatic chk(string tag, logic [31:0] exp);
        logic [31:0] act;
        act = pk(busy_o, sel_o, conv_o, pix_rst_o, pix_valid_o, frame_done_o, row_o, col_o);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic noise_drive(bit noise);
        if (noise) begin
            start_i      = 1'($urandom % 2);
            mode_reset_i = 1'($urandom % 2);
            win_en_i     = 1'($urandom % 2);
            win_row_i    = AW'($urandom);
            win_col_i    = AW'($urandom);
            settle_i     = SB'($urandom);
        end else begin
            start_i = 1'b0;
        end
    endtask

    // Runs one scan from idle at a negedge and checks every cycle.
    task automatic run_scan(bit rmode, bit win, int orow, int ocol, int s, bit noise);
        int r0, c0, r1, c1;
        string st;
        logic [NQ-1:0] cv;
        st = win ? ((orow > Q - W || ocol > Q - W) ? "R3 R4" : "R3") : "R2";
        if (noise) st = {st, " R9"};
        r0 = win ? clampf(orow) : 0;
        c0 = win ? clampf(ocol) : 0;
        r1 = win ? r0 + W - 1 : Q - 1;
        c1 = win ? c0 + W - 1 : Q - 1;
        cv = rmode ? '0 : '1;
        start_i = 1'b1; mode_reset_i = rmode; win_en_i = win;
        win_row_i = AW'(orow); win_col_i = AW'(ocol); settle_i = SB'(s);
        @(negedge clk);
        for (int r = r0; r <= r1; r++) begin
            for (int c = c0; c <= c1; c++) begin
                for (int k = 0; k <= s; k++) begin
                    chk({st, " R5 settle"}, pk(1, 1, '0, 0, 0, 0, AW'(r), AW'(c)));
                    noise_drive(noise);
                    @(negedge clk);
                end
                chk({st, rmode ? " R7 reset strobe" : " R6 convert strobe"},
                    pk(1, 1, cv, rmode, !rmode, 0, AW'(r), AW'(c)));
                noise_drive(noise);
                @(negedge clk);
            end
        end
        chk({st, " R8 frame done"}, pk(1, 0, '0, 0, 0, 1, AW'(r1), AW'(c1)));
        noise_drive(noise);
        @(negedge clk);
        chk({st, " R8 idle after done"}, pk(0, 0, '0, 0, 0, 0, AW'(r1), AW'(c1)));
        start_i = 1'b0;
        @(negedge clk);
        chk({st, " R9 no restart"}, pk(0, 0, '0, 0, 0, 0, AW'(r1), AW'(c1)));
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        int unsigned seed_v;
        seed_v = $urandom(32'd7531);
        repeat (3) @(negedge clk);
        chk("R1 in reset", pk(0, 0, '0, 0, 0, 0, '0, '0));
        rst_n = 1'b1;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            chk("R1 idle after reset", pk(0, 0, '0, 0, 0, 0, '0, '0));
        end
        // Directed corners
        run_scan(0, 0, 0, 0, 0, 0);
        run_scan(1, 0, 5, 5, 3, 0);
        run_scan(0, 1, 0, 0, 1, 0);
        run_scan(1, 1, Q - W, Q - W, 0, 0);
        run_scan(0, 1, Q - 1, 3, 2, 1);
        run_scan(0, 1, Q - W + 1, Q - 1, 0, 1);
        run_scan(1, 1, 7, Q - W + 1, 5, 1);
        run_scan(0, 0, 0, 0, 1, 1);
        // Constrained random mix
        for (int n = 0; n < 30; n++) begin
            run_scan(1'($urandom % 2), 1'b1, int'($urandom % Q), int'($urandom % Q),
                     int'($urandom % 8), 1'($urandom % 2));
        end
        for (int n = 0; n < 2; n++) begin
            run_scan(1'($urandom % 2), 1'b0, 0, 0, int'($urandom % 4), 1'($urandom % 2));
        end
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule